// File: doc/BRIEF.md
# Second-Operand Shifter and Immediate Expander

This combinational unit prepares the second ALU operand for a 32-bit RISC datapath. In shift mode it takes a register value and applies one of four shift kinds. The shift amount comes either from a 5-bit field in the instruction or from the low byte of a second register. The unit returns the shifted value and the carry produced by the shift. The ALU uses that carry as the C flag when an instruction updates flags. A zero immediate amount has a special meaning: for the right shifts it means a shift of 32, and for the rotate it selects a one-bit rotate through the incoming carry.

In constant mode the unit ignores the shift inputs. It zero-extends an 8-bit constant and rotates it right by twice a 4-bit rotate field, so every even rotation from 0 to 30 is available. The carry passes through unchanged when the rotate field is zero. Otherwise the carry copies the top bit of the constant.

The unit has no clock. Decode drives its inputs and reads its outputs in the same cycle.

Top module: `op2_shifter`

## Requirements
- R1: With `shift_kind`=2'b00 (left logical) and an amount of 1 to 31, `operand_out` is the input shifted left with zeros entering at the bottom, and `carry_out` is the last bit shifted out, input bit 32-n.
- R2: With `shift_kind`=2'b01 (right logical) and an amount of 1 to 31, zeros enter at the top, and `carry_out` is input bit n-1.
- R3: With `shift_kind`=2'b10 (right arithmetic) and an amount of 1 to 31, copies of bit 31 enter at the top, and `carry_out` is input bit n-1.
- R4: With `shift_kind`=2'b11 (rotate) and a rotation of 1 to 31, bits leaving the bottom re-enter at the top, and `carry_out` equals bit 31 of the result.
- R5: With `amt_src`=0, `shift_kind`=2'b11 and `amt_imm`=0, the result is {`carry_in`, input[31:1]} and `carry_out` is input bit 0.
- R6: With `amt_src`=0 and `amt_imm`=0, a left logical shift passes the input and `carry_in` unchanged. Right logical and right arithmetic act as a shift by 32.
- R7: With `amt_src`=1 and `amt_reg`=0, every shift kind passes the input and `carry_in` unchanged.
- R8: With `amt_src`=1, left and right logical shifts by exactly 32 give zero, with carry equal to input bit 0 (left) or input bit 31 (right). Amounts above 32 give zero with carry 0.
- R9: With `amt_src`=1 and right arithmetic by 32 or more, every result bit and `carry_out` equal input bit 31.
- R10: With `amt_src`=1, a rotate uses the amount modulo 32. A non-zero multiple of 32 returns the input unchanged, with `carry_out` equal to input bit 31.
- R11: With `imm_mode`=1, `operand_out` is the zero-extended `imm_byte` rotated right by 2×`imm_rot`, and all shift inputs are ignored. For example, byte 0x40 with rotate field 0xD gives 0x00001000.
- R12: With `imm_mode`=1, `carry_out` equals `carry_in` when `imm_rot`=0 and bit 31 of the result otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_in | input | DATA_W | Register value to shift |
| shift_kind | input | 2 | 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate |
| amt_src | input | 1 | 0: amount from `amt_imm`, 1: amount from `amt_reg` |
| amt_imm | input | SH_W (5) | Instruction-field shift amount |
| amt_reg | input | AMT_W (8) | Low byte of the amount register |
| carry_in | input | 1 | Current C flag |
| imm_mode | input | 1 | 1 selects the rotated-constant operand |
| imm_byte | input | IMM_W (8) | Constant byte |
| imm_rot | input | ROT_W (4) | Rotate field; the rotation is twice this value |
| operand_out | output | DATA_W | Second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 5-bit immediate amount, an 8-bit register amount, an 8-bit constant and a 4-bit rotate field. The 8-bit register amount lets the bench reach amounts of exactly 32, just above 32, and up to 255, including non-zero multiples of 32 for the rotate. The 32-bit width makes the published constant example (0x40 with rotate field 0xD) directly checkable, together with the zero-amount encodings and the rotate through carry.

// File: rtl/op2_pkg.sv
package op2_pkg;

    // Internal shift operation after the immediate special cases are resolved
    typedef enum logic [2:0] {
        OP_LSL = 3'd0,
        OP_LSR = 3'd1,
        OP_ASR = 3'd2,
        OP_ROR = 3'd3,
        OP_RRX = 3'd4
    } shift_op_e;

    // Port-level encoding of shift_kind
    localparam logic [1:0] KIND_LSL = 2'b00;
    localparam logic [1:0] KIND_LSR = 2'b01;
    localparam logic [1:0] KIND_ASR = 2'b10;
    localparam logic [1:0] KIND_ROR = 2'b11;

endpackage

// File: rtl/op2_amount_decode.sv
module op2_amount_decode
    import op2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [1:0]       kind,
    input  logic             amt_src,
    input  logic [SH_W-1:0]  amt_imm,
    input  logic [AMT_W-1:0] amt_reg,
    output shift_op_e        op,
    output logic [AMT_W-1:0] amt
);

    always_comb begin
        unique case (kind)
            KIND_LSL: op = OP_LSL;
            KIND_LSR: op = OP_LSR;
            KIND_ASR: op = OP_ASR;
            default:  op = OP_ROR;
        endcase

        if (amt_src) begin
            amt = amt_reg;
        end else begin
            amt = AMT_W'(amt_imm);
            // A zero instruction amount carries a special meaning for three kinds
            if (amt_imm == '0) begin
                unique case (kind)
                    KIND_LSR, KIND_ASR: amt = AMT_W'(DATA_W);
                    KIND_ROR: begin
                        op  = OP_RRX;
                        amt = AMT_W'(1);
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/op2_shift_core.sv
module op2_shift_core
    import op2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  shift_op_e         op,
    input  logic [AMT_W-1:0]  amt,
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    output logic [DATA_W-1:0] dout,
    output logic              cout
);

    // One extra bit on each shifter holds the last bit shifted out
    logic [DATA_W:0]   up_ext;
    logic [DATA_W:0]   dn_ext;
    logic [DATA_W:0]   ar_ext;
    logic [SH_W-1:0]   rot_amt;
    logic [DATA_W-1:0] rot_val;

    always_comb begin
        up_ext  = {1'b0, din} << amt;
        dn_ext  = {din, 1'b0} >> amt;
        ar_ext  = $signed({din, 1'b0}) >>> amt;
        rot_amt = amt[SH_W-1:0];
        rot_val = (din >> rot_amt) | (din << (DATA_W - int'(rot_amt)));
    end

    always_comb begin
        dout = din;
        cout = cin;
        if (op == OP_RRX) begin
            {dout, cout} = {cin, din};
        end else if (amt != '0) begin
            unique case (op)
                OP_LSL: {cout, dout} = up_ext;
                OP_LSR: {dout, cout} = dn_ext;
                OP_ASR: {dout, cout} = ar_ext;
                OP_ROR: begin
                    dout = rot_val;
                    cout = rot_val[DATA_W-1];
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/op2_imm_expand.sv
module op2_imm_expand #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    input  logic              cin,
    output logic [DATA_W-1:0] val,
    output logic              cout
);

    logic [SH_W-1:0]     rot_amt;
    logic [DATA_W-1:0]   base;
    logic [2*DATA_W-1:0] dbl;

    always_comb begin
        rot_amt = SH_W'({imm_rot, 1'b0});
        base    = DATA_W'(imm_byte);
        dbl     = {base, base} >> rot_amt;
        val     = dbl[DATA_W-1:0];
        cout    = (imm_rot == '0) ? cin : val[DATA_W-1];
    end

endmodule

// File: rtl/op2_shifter.sv
module op2_shifter
    import op2_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [1:0]        shift_kind,
    input  logic              amt_src,
    input  logic [SH_W-1:0]   amt_imm,
    input  logic [AMT_W-1:0]  amt_reg,
    input  logic              carry_in,
    input  logic              imm_mode,
    input  logic [IMM_W-1:0]  imm_byte,
    input  logic [ROT_W-1:0]  imm_rot,
    output logic [DATA_W-1:0] operand_out,
    output logic              carry_out
);

    shift_op_e         dec_op;
    logic [AMT_W-1:0]  dec_amt;
    logic [DATA_W-1:0] sh_val;
    logic              sh_c;
    logic [DATA_W-1:0] im_val;
    logic              im_c;

    op2_amount_decode #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_dec (
        .kind    (shift_kind),
        .amt_src (amt_src),
        .amt_imm (amt_imm),
        .amt_reg (amt_reg),
        .op      (dec_op),
        .amt     (dec_amt)
    );

    op2_shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_core (
        .op   (dec_op),
        .amt  (dec_amt),
        .din  (opnd_in),
        .cin  (carry_in),
        .dout (sh_val),
        .cout (sh_c)
    );

    op2_imm_expand #(.DATA_W(DATA_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) i_imm (
        .imm_byte (imm_byte),
        .imm_rot  (imm_rot),
        .cin      (carry_in),
        .val      (im_val),
        .cout     (im_c)
    );

    always_comb begin
        operand_out = imm_mode ? im_val : sh_val;
        carry_out   = imm_mode ? im_c   : sh_c;
    end

endmodule

// File: rtl/op2_shifter_chk.sv
module op2_shifter_chk #(
    parameter int DATA_W = 32,
    parameter int AMT_W  = 8,
    parameter int IMM_W  = 8,
    parameter int ROT_W  = 4,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input logic [DATA_W-1:0] opnd_in,
    input logic [1:0]        shift_kind,
    input logic              amt_src,
    input logic [SH_W-1:0]   amt_imm,
    input logic [AMT_W-1:0]  amt_reg,
    input logic              carry_in,
    input logic              imm_mode,
    input logic [IMM_W-1:0]  imm_byte,
    input logic [ROT_W-1:0]  imm_rot,
    input logic [DATA_W-1:0] operand_out,
    input logic              carry_out
);

    logic reg_mode;
    assign reg_mode = !imm_mode && amt_src;

    always_comb begin
        if (reg_mode && amt_reg == '0)
            AST_REG_ZERO_PASS: assert (operand_out == opnd_in && carry_out == carry_in); // R7
        if (!imm_mode && shift_kind == 2'b11)
            AST_ROT_KEEPS_ONES: assert ($countones(operand_out) ==
                                        $countones(opnd_in) + int'(carry_in) - int'(carry_out)
                                        || amt_src || amt_imm != '0); // R5
        if (!imm_mode && shift_kind == 2'b11 && (amt_src || amt_imm != '0))
            AST_ROR_SAME_ONES: assert ($countones(operand_out) == $countones(opnd_in)); // R4
        if (reg_mode && shift_kind == 2'b00 && int'(amt_reg) > DATA_W)
            AST_LSL_BIG_ZERO: assert (operand_out == '0 && !carry_out); // R8
        if (reg_mode && shift_kind == 2'b10 && int'(amt_reg) >= DATA_W)
            AST_ASR_BIG_SIGN: assert (operand_out == {DATA_W{opnd_in[DATA_W-1]}}
                                      && carry_out == opnd_in[DATA_W-1]); // R9
        if (imm_mode)
            AST_IMM_SAME_ONES: assert ($countones(operand_out) == $countones(imm_byte)); // R11
        if (imm_mode && imm_rot != '0)
            AST_IMM_CARRY_TOP: assert (carry_out == operand_out[DATA_W-1]); // R12
        if (imm_mode && imm_rot == '0)
            AST_IMM_CARRY_KEEP: assert (carry_out == carry_in); // R12
    end

endmodule

bind op2_shifter op2_shifter_chk #(
    .DATA_W (DATA_W),
    .AMT_W  (AMT_W),
    .IMM_W  (IMM_W),
    .ROT_W  (ROT_W)
) i_chk (.*);

// File: tb/test_op2_shifter.sv
module test_op2_shifter;

    localparam int W = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    logic [W-1:0] opnd_in;
    logic [1:0]   shift_kind;
    logic         amt_src;
    logic [4:0]   amt_imm;
    logic [7:0]   amt_reg;
    logic         carry_in;
    logic         imm_mode;
    logic [7:0]   imm_byte;
    logic [3:0]   imm_rot;
    logic [W-1:0] operand_out;
    logic         carry_out;

    op2_shifter i_op2_shifter (
        .opnd_in     (opnd_in),
        .shift_kind  (shift_kind),
        .amt_src     (amt_src),
        .amt_imm     (amt_imm),
        .amt_reg     (amt_reg),
        .carry_in    (carry_in),
        .imm_mode    (imm_mode),
        .imm_byte    (imm_byte),
        .imm_rot     (imm_rot),
        .operand_out (operand_out),
        .carry_out   (carry_out)
    );

    typedef struct {
        string        tag;
        logic [W:0]   exp;
    } item_t;

    item_t q[$];
    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // Bit-serial reference built from the requirements: {carry, value}
    function automatic logic [W:0] model(logic [1:0] k, logic src, logic [4:0] ai,
                                         logic [7:0] ar, logic [W-1:0] x, logic ci,
                                         logic im, logic [7:0] ib, logic [3:0] ir);
        logic [W-1:0] v;
        logic c;
        int n;
        if (im) begin
            v = {24'b0, ib};
            for (int i = 0; i < 2 * int'(ir); i++) v = {v[0], v[W-1:1]};
            c = (ir == 0) ? ci : v[W-1];
            return {c, v};
        end
        n = src ? int'(ar) : int'(ai);
        if (!src && ai == 0) begin
            if (k == 2'b11) return {x[0], ci, x[W-1:1]};
            if (k != 2'b00) n = 32;
        end
        v = x;
        c = ci;
        for (int i = 0; i < n; i++) begin
            case (k)
                2'b00: begin c = v[W-1]; v = {v[W-2:0], 1'b0}; end
                2'b01: begin c = v[0]; v = {1'b0, v[W-1:1]}; end
                2'b10: begin c = v[0]; v = {v[W-1], v[W-1:1]}; end
                default: begin c = v[0]; v = {v[0], v[W-1:1]}; end
            endcase
        end
        return {c, v};
    endfunction

    task automatic drive(string tag, logic [W-1:0] x, logic [1:0] k, logic src,
                         logic [4:0] ai, logic [7:0] ar, logic ci,
                         logic im, logic [7:0] ib, logic [3:0] ir);
        item_t it;
        @(posedge clk);
        #1;
        opnd_in = x; shift_kind = k; amt_src = src; amt_imm = ai; amt_reg = ar;
        carry_in = ci; imm_mode = im; imm_byte = ib; imm_rot = ir;
        it.tag = tag;
        it.exp = model(k, src, ai, ar, x, ci, im, ib, ir);
        q.push_back(it);
    endtask

    task automatic drive_exp(string tag, logic [W-1:0] x, logic [1:0] k, logic src,
                             logic [4:0] ai, logic [7:0] ar, logic ci,
                             logic im, logic [7:0] ib, logic [3:0] ir, logic [W:0] e);
        item_t it;
        @(posedge clk);
        #1;
        opnd_in = x; shift_kind = k; amt_src = src; amt_imm = ai; amt_reg = ar;
        carry_in = ci; imm_mode = im; imm_byte = ib; imm_rot = ir;
        it.tag = tag;
        it.exp = e;
        q.push_back(it);
    endtask

    // Monitor: compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            total++;
            if ({carry_out, operand_out} !== it.exp) begin
                bad++;
                $display("FAIL %s: got c=%0b v=%08h expected c=%0b v=%08h", it.tag,
                         carry_out, operand_out, it.exp[W], it.exp[W-1:0]);
            end
        end
    end

    initial begin
        opnd_in = '0; shift_kind = 2'b00; amt_src = 1'b0; amt_imm = '0; amt_reg = '0;
        carry_in = 1'b0; imm_mode = 1'b0; imm_byte = '0; imm_rot = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // Idle state: everything zero gives zero (R6 pass-through)
        drive_exp("R6", '0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, 33'h0);
        // Hand-computed corner cases
        drive_exp("R1", 32'h8000_0001, 2'b00, 1'b0, 5'd1, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'h0000_0002});
        drive_exp("R2", 32'h0000_0003, 2'b01, 1'b0, 5'd1, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'h0000_0001});
        drive_exp("R3", 32'h8000_0000, 2'b10, 1'b0, 5'd4, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, {1'b0, 32'hF800_0000});
        drive_exp("R4", 32'h0000_0001, 2'b11, 1'b0, 5'd1, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'h8000_0000});
        drive_exp("R5", 32'h0000_0003, 2'b11, 1'b0, 5'd0, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'h0000_0001});
        drive_exp("R5", 32'h0000_0002, 2'b11, 1'b0, 5'd0, 8'd0, 1'b1, 1'b0, 8'd0, 4'd0, {1'b0, 32'h8000_0001});
        drive_exp("R6", 32'h1234_5678, 2'b00, 1'b0, 5'd0, 8'd0, 1'b1, 1'b0, 8'd0, 4'd0, {1'b1, 32'h1234_5678});
        drive_exp("R6", 32'h8000_0000, 2'b01, 1'b0, 5'd0, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'h0});
        drive_exp("R6", 32'h8000_0000, 2'b10, 1'b0, 5'd0, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'hFFFF_FFFF});
        drive_exp("R7", 32'hCAFE_F00D, 2'b10, 1'b1, 5'd7, 8'd0, 1'b1, 1'b0, 8'd0, 4'd0, {1'b1, 32'hCAFE_F00D});
        drive_exp("R8", 32'h0000_0001, 2'b00, 1'b1, 5'd0, 8'd32, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'h0});
        drive_exp("R8", 32'hFFFF_FFFF, 2'b01, 1'b1, 5'd0, 8'd33, 1'b1, 1'b0, 8'd0, 4'd0, {1'b0, 32'h0});
        drive_exp("R9", 32'h8000_0000, 2'b10, 1'b1, 5'd0, 8'd200, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'hFFFF_FFFF});
        drive_exp("R10", 32'h8765_4321, 2'b11, 1'b1, 5'd0, 8'd64, 1'b0, 1'b0, 8'd0, 4'd0, {1'b1, 32'h8765_4321});
        drive_exp("R10", 32'h0000_0010, 2'b11, 1'b1, 5'd0, 8'd36, 1'b0, 1'b0, 8'd0, 4'd0, {1'b0, 32'h0000_0001});
        drive_exp("R11", 32'hFFFF_FFFF, 2'b01, 1'b1, 5'd3, 8'd9, 1'b0, 1'b1, 8'h40, 4'hD, {1'b0, 32'h0000_1000});
        drive_exp("R12", 32'h0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b1, 1'b1, 8'hFF, 4'h0, {1'b1, 32'h0000_00FF});
        drive_exp("R12", 32'h0, 2'b00, 1'b0, 5'd0, 8'd0, 1'b0, 1'b1, 8'h0F, 4'h2, {1'b1, 32'hF000_0000});
        // Sweeps over every immediate amount for each kind
        for (int n = 1; n < 32; n++) begin
            drive("R1", $urandom, 2'b00, 1'b0, 5'(n), 8'd0, 1'($urandom), 1'b0, 8'd0, 4'd0);
            drive("R2", $urandom, 2'b01, 1'b0, 5'(n), 8'd0, 1'($urandom), 1'b0, 8'd0, 4'd0);
            drive("R3", $urandom, 2'b10, 1'b0, 5'(n), 8'd0, 1'($urandom), 1'b0, 8'd0, 4'd0);
            drive("R4", $urandom, 2'b11, 1'b0, 5'(n), 8'd0, 1'($urandom), 1'b0, 8'd0, 4'd0);
        end
        // Register amounts including the 32 boundary and large values
        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [1:0] k;
            k = 2'($urandom);
            case (i % 5)
                0: a = 8'd32;
                1: a = 8'd31;
                2: a = 8'd33;
                3: a = 8'(32 * ($urandom % 8));
                default: a = 8'($urandom);
            endcase
            if (k == 2'b10)      drive("R9", $urandom, k, 1'b1, 5'($urandom), a, 1'($urandom), 1'b0, 8'($urandom), 4'($urandom));
            else if (k == 2'b11) drive("R10", $urandom, k, 1'b1, 5'($urandom), a, 1'($urandom), 1'b0, 8'($urandom), 4'($urandom));
            else                 drive("R8", $urandom, k, 1'b1, 5'($urandom), a, 1'($urandom), 1'b0, 8'($urandom), 4'($urandom));
        end
        // Every rotate field for the constant path
        for (int r = 0; r < 16; r++) begin
            drive("R11", $urandom, 2'($urandom), 1'($urandom), 5'($urandom), 8'($urandom),
                  1'($urandom), 1'b1, 8'($urandom), 4'(r));
            drive("R12", $urandom, 2'($urandom), 1'($urandom), 5'($urandom), 8'($urandom),
                  1'($urandom), 1'b1, 8'h81, 4'(r));
        end
        @(posedge clk);
        wait (q.size() == 0);
        @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: got running expected finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule